// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the 32-bit memory-mapped register front end of a sixteen-channel DMA controller whose channels walk chains of control blocks held in memory. It turns single word accesses into per-channel register windows and a small global area. For each channel it keeps a control/status word, a control-block pointer, a scratch debug word and read-only copies of the descriptor that the transfer engine is working on. Globally it keeps a per-channel enable mask and an interrupt summary, and it drives one interrupt line per channel.

The transfer engine sits beside the block. It receives a one-cycle start pulse when software turns a channel on. It reports back through per-channel strobes: transfer finished, end flag set and interrupt set. It also loads the descriptor copies. Channels 0 to NCH-2 live in the main window, at bits [11:8] of the address. The last channel is reached through a second window of its own, chosen by `bus_win`.

Top module: `dma_regbank`

## Requirements
- R1: With `bus_win`=0, an address below 0xF00 selects channel `bus_addr[11:8]` for indices 0 to NCH-2 and register `bus_addr[7:0]`. With `bus_win`=1, channel NCH-1 is selected with register `bus_addr[7:0]` and bits [11:8] are ignored. The register offsets are: 0x00 status word, 0x04 control-block pointer, 0x20 debug, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride and 0x1C next pointer.
- R2: After reset, every status word and control-block pointer reads 0, the interrupt summary and all `irq` lines are 0, and the enable mask reads all ones in its low NCH bits.
- R3: The control-block pointer and the debug word read back what was written. The six descriptor copies read the values present on the `desc_*` buses in the cycle where `desc_load[c]` was high. Bus writes to these copies are dropped.
- R4: A status-word write replaces bits 0, 16 to 23, 28 and 29 (mask 0x30FF0001) with the written value and keeps all other bits. Bits 30 and 31 always read 0.
- R5: A status-word write with bit 31 set first clears that channel's whole status word and its control-block pointer. The masked update of R4 is applied afterwards.
- R6: A status-word write with bit 1 set clears the end flag (bit 1). A write with bit 2 set clears the interrupt flag (bit 2), the channel's summary bit and its `irq` line.
- R7: `start_pulse[c]` is high for one cycle, in the cycle after a status-word write that took bit 0 from 0 to 1 while enable bit c was set. No other write starts a channel. Writing bit 30 has no effect beyond the R4 mask.
- R8: `eng_done[c]` clears bit 0 and sets the paused flag (bit 4). `eng_end_set[c]` sets bit 1. `eng_int_set[c]` sets bit 2, the summary bit and `irq[c]`. These take effect on the next edge, after any same-cycle bus write.
- R9: Main-window offset 0xFE0 reads the interrupt summary, one bit per channel, and ignores writes. Offset 0xFF0 holds the enable mask, which keeps the low NCH bits of a write.
- R10: Any other offset, including channel indices at or above NCH-1 in the main window, reads as 0 and drops writes. Read data is 0 whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = main window, 1 = last-channel window |
| bus_addr | input | AW | Byte offset within the window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, same cycle |
| eng_done | input | NCH | Engine finished the channel |
| eng_end_set | input | NCH | Engine sets the end flag |
| eng_int_set | input | NCH | Engine raises the channel interrupt |
| desc_load | input | NCH | Load descriptor copies of the channel |
| desc_info | input | DW | Descriptor info word |
| desc_src | input | DW | Descriptor source address |
| desc_dst | input | DW | Descriptor destination address |
| desc_len | input | DW | Descriptor transfer length |
| desc_stride | input | DW | Descriptor stride word |
| desc_next | input | DW | Descriptor next pointer |
| start_pulse | output | NCH | One-cycle start request per channel |
| irq | output | NCH | Per-channel interrupt line |

## Verification
The assertions assume that the bus presents at most one access per cycle. They also assume that an engine strobe for a channel is raised only as a single-cycle event, not held. Under these assumptions a start pulse always traces back to a write in the cycle before it, and a done or interrupt strobe is visible in the status word one edge later. The stimulus drives exactly one access or one group of engine strobes per cycle, each from a task that sets every input, so no strobe is ever held across cycles. Read checks always come from a behavioural model of the status rules, and that model runs on every clock edge.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

   localparam int REG_W = 32;

   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_CBPTR  = 8'h04;
   localparam logic [7:0] OFS_INFO   = 8'h08;
   localparam logic [7:0] OFS_SRC    = 8'h0C;
   localparam logic [7:0] OFS_DST    = 8'h10;
   localparam logic [7:0] OFS_LEN    = 8'h14;
   localparam logic [7:0] OFS_STRIDE = 8'h18;
   localparam logic [7:0] OFS_NEXT   = 8'h1C;
   localparam logic [7:0] OFS_DEBUG  = 8'h20;

   localparam logic [11:0] OFS_GLB_LIMIT = 12'hF00;
   localparam logic [11:0] OFS_IRQSUM   = 12'hFE0;
   localparam logic [11:0] OFS_ENMASK   = 12'hFF0;

   localparam logic [REG_W-1:0] CTRL_RW_MASK = 32'h30FF_0001;

   localparam int B_RUN    = 0;
   localparam int B_END    = 1;
   localparam int B_INT    = 2;
   localparam int B_PAUSED = 4;
   localparam int B_CLRALL = 31;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_CTRL, SEL_CBPTR, SEL_INFO, SEL_SRC,
      SEL_DST, SEL_LEN, SEL_STRIDE, SEL_NEXT, SEL_DEBUG
   } reg_sel_e;

   typedef struct packed {
      logic [REG_W-1:0] info;
      logic [REG_W-1:0] src;
      logic [REG_W-1:0] dst;
      logic [REG_W-1:0] len;
      logic [REG_W-1:0] stride;
      logic [REG_W-1:0] nxt;
   } desc_t;

endpackage

// File: rtl/dma_regbank_decode.sv
module dma_regbank_decode
   import dma_regbank_pkg::*;
#(
   parameter int NCH = 16,
   parameter int AW  = 12,
   localparam int IW = AW - 8
) (
   input  logic          win,
   input  logic [AW-1:0] addr,
   output logic [IW-1:0] chan_idx,
   output logic          chan_hit,
   output reg_sel_e      reg_sel,
   output logic          irqsum_hit,
   output logic          enmask_hit
);

   logic [7:0] ofs;

   assign ofs = addr[7:0];

   always_comb begin
      chan_idx   = '0;
      chan_hit   = 1'b0;
      irqsum_hit = 1'b0;
      enmask_hit = 1'b0;
      if (win) begin
         chan_idx = IW'(NCH - 1);
         chan_hit = 1'b1;
      end else if (addr < OFS_GLB_LIMIT) begin
         chan_idx = addr[AW-1:8];
         chan_hit = (int'(addr[AW-1:8]) < NCH - 1);
      end else begin
         irqsum_hit = (addr == OFS_IRQSUM);
         enmask_hit = (addr == OFS_ENMASK);
      end
   end

   always_comb begin
      unique case (ofs)
         OFS_CTRL:   reg_sel = SEL_CTRL;
         OFS_CBPTR:  reg_sel = SEL_CBPTR;
         OFS_INFO:   reg_sel = SEL_INFO;
         OFS_SRC:    reg_sel = SEL_SRC;
         OFS_DST:    reg_sel = SEL_DST;
         OFS_LEN:    reg_sel = SEL_LEN;
         OFS_STRIDE: reg_sel = SEL_STRIDE;
         OFS_NEXT:   reg_sel = SEL_NEXT;
         OFS_DEBUG:  reg_sel = SEL_DEBUG;
         default:    reg_sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/dma_regbank_chan.sv
module dma_regbank_chan
   import dma_regbank_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ctrl,
   input  logic          wr_cbptr,
   input  logic          wr_debug,
   input  logic [DW-1:0] wdata,
   input  logic          en_bit,
   input  logic          eng_done,
   input  logic          eng_end,
   input  logic          eng_int,
   input  logic          desc_ld,
   input  desc_t         desc_in,
   output logic [DW-1:0] ctrl_q,
   output logic [DW-1:0] cbptr_q,
   output logic [DW-1:0] debug_q,
   output desc_t         desc_q,
   output logic          start_q,
   output logic          irq_q
);

   logic [DW-1:0] ctrl_wr;
   logic [DW-1:0] ctrl_nxt;
   logic          irq_nxt;
   logic          start_d;

   // status word after the clear actions and the masked replace
   always_comb begin
      ctrl_wr = ctrl_q;
      if (wdata[B_CLRALL]) ctrl_wr = '0;
      if (wdata[B_END])    ctrl_wr[B_END] = 1'b0;
      if (wdata[B_INT])    ctrl_wr[B_INT] = 1'b0;
      ctrl_wr = (ctrl_wr & ~CTRL_RW_MASK) | (wdata & CTRL_RW_MASK);
   end

   // engine strobes land after the bus write
   always_comb begin
      ctrl_nxt = wr_ctrl ? ctrl_wr : ctrl_q;
      if (eng_done) begin
         ctrl_nxt[B_RUN]    = 1'b0;
         ctrl_nxt[B_PAUSED] = 1'b1;
      end
      if (eng_end) ctrl_nxt[B_END] = 1'b1;
      if (eng_int) ctrl_nxt[B_INT] = 1'b1;
   end

   always_comb begin
      irq_nxt = irq_q;
      if (wr_ctrl && wdata[B_INT]) irq_nxt = 1'b0;
      if (eng_int)                 irq_nxt = 1'b1;
   end

   assign start_d = wr_ctrl && !ctrl_q[B_RUN] && ctrl_wr[B_RUN] && en_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cbptr_q <= '0;
         debug_q <= '0;
         desc_q  <= '0;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         ctrl_q  <= ctrl_nxt;
         irq_q   <= irq_nxt;
         start_q <= start_d;
         if (wr_ctrl && wdata[B_CLRALL]) cbptr_q <= '0;
         else if (wr_cbptr)              cbptr_q <= wdata;
         if (wr_debug) debug_q <= wdata;
         if (desc_ld)  desc_q  <= desc_in;
      end
   end

endmodule

// File: rtl/dma_regbank_enmask.sv
module dma_regbank_enmask #(
   parameter int NCH = 16,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [DW-1:0]  wdata,
   output logic [NCH-1:0] en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '1;
      else if (wr) en_q <= wdata[NCH-1:0];
   end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
   import dma_regbank_pkg::*;
#(
   parameter int NCH = 16,
   parameter int AW  = 12,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_valid,
   input  logic           bus_write,
   input  logic           bus_win,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   input  logic [NCH-1:0] eng_done,
   input  logic [NCH-1:0] eng_end_set,
   input  logic [NCH-1:0] eng_int_set,
   input  logic [NCH-1:0] desc_load,
   input  logic [DW-1:0]  desc_info,
   input  logic [DW-1:0]  desc_src,
   input  logic [DW-1:0]  desc_dst,
   input  logic [DW-1:0]  desc_len,
   input  logic [DW-1:0]  desc_stride,
   input  logic [DW-1:0]  desc_next,
   output logic [NCH-1:0] start_pulse,
   output logic [NCH-1:0] irq
);

   localparam int IW = AW - 8;

   if (NCH < 2 || NCH > (1 << IW)) begin : g_bad_nch
      $error("dma_regbank: NCH out of range");
   end
   if (AW != 12) begin : g_bad_aw
      $error("dma_regbank: AW must be 12");
   end
   if (DW != REG_W) begin : g_bad_dw
      $error("dma_regbank: DW must match the package word width");
   end

   logic [IW-1:0]          chan_idx;
   logic                   chan_hit;
   reg_sel_e               reg_sel;
   logic                   irqsum_hit;
   logic                   enmask_hit;
   logic                   wr_acc;
   logic                   rd_acc;
   logic [NCH-1:0]         en_q;
   logic [NCH-1:0][DW-1:0] cs_all;
   logic [NCH-1:0][DW-1:0] cbptr_all;
   logic [NCH-1:0][DW-1:0] debug_all;
   desc_t [NCH-1:0]        desc_all;
   desc_t                  desc_in;

   assign wr_acc = bus_valid && bus_write;
   assign rd_acc = bus_valid && !bus_write;

   assign desc_in = '{info: desc_info, src: desc_src, dst: desc_dst,
                      len: desc_len, stride: desc_stride, nxt: desc_next};

   dma_regbank_decode #(.NCH(NCH), .AW(AW)) u_dec (
      .win        (bus_win),
      .addr       (bus_addr),
      .chan_idx   (chan_idx),
      .chan_hit   (chan_hit),
      .reg_sel    (reg_sel),
      .irqsum_hit (irqsum_hit),
      .enmask_hit (enmask_hit)
   );

   dma_regbank_enmask #(.NCH(NCH), .DW(DW)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_acc && enmask_hit),
      .wdata (bus_wdata),
      .en_q  (en_q)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic sel_c;
      assign sel_c = wr_acc && chan_hit && (chan_idx == IW'(c));

      dma_regbank_chan #(.DW(DW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_ctrl  (sel_c && reg_sel == SEL_CTRL),
         .wr_cbptr (sel_c && reg_sel == SEL_CBPTR),
         .wr_debug (sel_c && reg_sel == SEL_DEBUG),
         .wdata    (bus_wdata),
         .en_bit   (en_q[c]),
         .eng_done (eng_done[c]),
         .eng_end  (eng_end_set[c]),
         .eng_int  (eng_int_set[c]),
         .desc_ld  (desc_load[c]),
         .desc_in  (desc_in),
         .ctrl_q   (cs_all[c]),
         .cbptr_q  (cbptr_all[c]),
         .debug_q  (debug_all[c]),
         .desc_q   (desc_all[c]),
         .start_q  (start_pulse[c]),
         .irq_q    (irq[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         if (chan_hit) begin
            unique case (reg_sel)
               SEL_CTRL:   bus_rdata = cs_all[chan_idx];
               SEL_CBPTR:  bus_rdata = cbptr_all[chan_idx];
               SEL_DEBUG:  bus_rdata = debug_all[chan_idx];
               SEL_INFO:   bus_rdata = desc_all[chan_idx].info;
               SEL_SRC:    bus_rdata = desc_all[chan_idx].src;
               SEL_DST:    bus_rdata = desc_all[chan_idx].dst;
               SEL_LEN:    bus_rdata = desc_all[chan_idx].len;
               SEL_STRIDE: bus_rdata = desc_all[chan_idx].stride;
               SEL_NEXT:   bus_rdata = desc_all[chan_idx].nxt;
               default:    bus_rdata = '0;
            endcase
         end else if (irqsum_hit) begin
            bus_rdata = DW'(irq);
         end else if (enmask_hit) begin
            bus_rdata = DW'(en_q);
         end
      end
   end

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
   parameter int NCH = 16,
   parameter int DW  = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_valid,
   input logic                   bus_write,
   input logic [NCH-1:0]         start_pulse,
   input logic [NCH-1:0]         irq,
   input logic [NCH-1:0]         eng_done,
   input logic [NCH-1:0]         eng_int_set,
   input logic [NCH-1:0]         en_q,
   input logic [NCH-1:0][DW-1:0] cs_all
);

   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_pulse)); // R7

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse[c] |-> $past(bus_valid && bus_write)); // R7

      AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse[c] |-> $past(en_q[c])); // R7

      AST_DONE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
         eng_done[c] |=> (!cs_all[c][0] && cs_all[c][4])); // R8

      AST_INT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         eng_int_set[c] |=> (irq[c] && cs_all[c][2])); // R8

      AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         cs_all[c][31:30] == 2'b00); // R4
   end

endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid   (bus_valid),
   .bus_write   (bus_write),
   .start_pulse (start_pulse),
   .irq         (irq),
   .eng_done    (eng_done),
   .eng_int_set (eng_int_set),
   .en_q        (en_q),
   .cs_all      (cs_all)
);

// File: tb/dma_regbank_tb.sv
`timescale 1ns/1ps
module dma_regbank_tb;

   localparam int NCH = 16;
   localparam logic [31:0] RWM = 32'h30FF_0001;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_valid = 1'b0, bus_write = 1'b0, bus_win = 1'b0;
   logic [11:0]    bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NCH-1:0] eng_done = '0, eng_end_set = '0, eng_int_set = '0, desc_load = '0;
   logic [31:0]    desc_info = '0, desc_src = '0, desc_dst = '0;
   logic [31:0]    desc_len = '0, desc_stride = '0, desc_next = '0;
   logic [NCH-1:0] start_pulse, irq;

   int n_cmp = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   dma_regbank u_dut (.*);

   // behavioural model
   logic [31:0]    m_cs [NCH], m_cba [NCH], m_dbg [NCH];
   logic [31:0]    m_desc [NCH][6];
   logic [NCH-1:0] m_en, m_irq, m_start;

   function automatic int decode_ch(input logic win, input logic [11:0] a);
      if (win) return NCH - 1;
      if (a < 12'hF00 && int'(a[11:8]) < NCH - 1) return int'(a[11:8]);
      return -1;
   endfunction

   function automatic logic [31:0] m_read(input logic win, input logic [11:0] a);
      int ch;
      ch = decode_ch(win, a);
      if (ch >= 0) begin
         case (a[7:0])
            8'h00: return m_cs[ch];
            8'h04: return m_cba[ch];
            8'h08: return m_desc[ch][0];
            8'h0C: return m_desc[ch][1];
            8'h10: return m_desc[ch][2];
            8'h14: return m_desc[ch][3];
            8'h18: return m_desc[ch][4];
            8'h1C: return m_desc[ch][5];
            8'h20: return m_dbg[ch];
            default: return 32'h0;
         endcase
      end
      if (!win && a == 12'hFE0) return 32'(m_irq);
      if (!win && a == 12'hFF0) return 32'(m_en);
      return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_cs[c] = 0; m_cba[c] = 0; m_dbg[c] = 0;
            for (int k = 0; k < 6; k++) m_desc[c][k] = 0;
         end
         m_en = '1; m_irq = '0; m_start = '0;
      end else begin
         int ch;
         logic [31:0] t, old;
         m_start = '0;
         if (bus_valid && bus_write) begin
            ch = decode_ch(bus_win, bus_addr);
            if (ch >= 0) begin
               if (bus_addr[7:0] == 8'h00) begin
                  old = m_cs[ch];
                  t = m_cs[ch];
                  if (bus_wdata[31]) begin t = 0; m_cba[ch] = 0; end
                  if (bus_wdata[1]) t[1] = 1'b0;
                  if (bus_wdata[2]) begin t[2] = 1'b0; m_irq[ch] = 1'b0; end
                  t = (t & ~RWM) | (bus_wdata & RWM);
                  m_cs[ch] = t;
                  if (!old[0] && t[0] && m_en[ch]) m_start[ch] = 1'b1;
               end else if (bus_addr[7:0] == 8'h04) m_cba[ch] = bus_wdata;
               else if (bus_addr[7:0] == 8'h20) m_dbg[ch] = bus_wdata;
            end else if (!bus_win && bus_addr == 12'hFF0) begin
               m_en = bus_wdata[NCH-1:0];
            end
         end
         for (int c = 0; c < NCH; c++) begin
            if (eng_done[c]) begin m_cs[c][0] = 1'b0; m_cs[c][4] = 1'b1; end
            if (eng_end_set[c]) m_cs[c][1] = 1'b1;
            if (eng_int_set[c]) begin m_cs[c][2] = 1'b1; m_irq[c] = 1'b1; end
            if (desc_load[c]) begin
               m_desc[c][0] = desc_info; m_desc[c][1] = desc_src;
               m_desc[c][2] = desc_dst;  m_desc[c][3] = desc_len;
               m_desc[c][4] = desc_stride; m_desc[c][5] = desc_next;
            end
         end
      end
   end

   // per-clock comparison of the registered outputs
   always @(negedge clk) begin
      if (rst_n) begin
         n_cmp++;
         if (start_pulse !== m_start) begin
            n_bad++;
            $display("FAIL R7 start_pulse actual=%h expected=%h", start_pulse, m_start);
         end
         n_cmp++;
         if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL R8/R6 irq actual=%h expected=%h", irq, m_irq);
         end
      end
   end

   task automatic idle_inputs();
      bus_valid = 0; bus_write = 0; bus_win = 0; bus_addr = '0; bus_wdata = '0;
      eng_done = '0; eng_end_set = '0; eng_int_set = '0; desc_load = '0;
   endtask

   task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      idle_inputs();
      bus_valid = 1; bus_write = 1; bus_win = win; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic win, input logic [11:0] a, input string req);
      logic [31:0] exp;
      @(negedge clk);
      idle_inputs();
      bus_valid = 1; bus_write = 0; bus_win = win; bus_addr = a;
      #1;
      exp = m_read(win, a);
      n_cmp++;
      if (bus_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s read win=%0d addr=%h actual=%h expected=%h",
                  req, win, a, bus_rdata, exp);
      end
   endtask

   task automatic eng(input int ch, input logic d, input logic e, input logic i);
      @(negedge clk);
      idle_inputs();
      eng_done[ch] = d; eng_end_set[ch] = e; eng_int_set[ch] = i;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); idle_inputs(); end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 reset state
      rd(0, 12'h000, "R2"); rd(0, 12'h304, "R2");
      rd(0, 12'hFF0, "R2"); rd(0, 12'hFE0, "R2"); rd(1, 12'h000, "R2");
      // R3 pointer, debug, descriptor copies
      wr(0, 12'h204, 32'h1234_5670); wr(0, 12'h220, 32'hCAFE_F00D);
      rd(0, 12'h204, "R3"); rd(0, 12'h220, "R3");
      wr(0, 12'h208, 32'hDEAD_BEEF); rd(0, 12'h208, "R3");
      @(negedge clk); idle_inputs();
      desc_load[5] = 1; desc_info = 32'h11; desc_src = 32'h2222; desc_dst = 32'h3333;
      desc_len = 32'h40; desc_stride = 32'h0010_0020; desc_next = 32'h8000;
      for (int k = 0; k < 6; k++) rd(0, 12'h508 + 12'(4*k), "R3");
      wr(0, 12'h50C, 32'h0); rd(0, 12'h50C, "R3");
      // R4 masked update
      wr(0, 12'h100, 32'hFFFF_FFFE); rd(0, 12'h100, "R4");
      wr(0, 12'h100, 32'h0); rd(0, 12'h100, "R4");
      // R7 start and ABORT
      wr(0, 12'h100, 32'h1); rd(0, 12'h100, "R7");
      wr(0, 12'h100, 32'h4000_0001); rd(0, 12'h100, "R7");
      // R8 engine strobes
      eng(1, 1, 1, 1); rd(0, 12'h100, "R8"); rd(0, 12'hFE0, "R8");
      // R6 write-one-to-clear
      wr(0, 12'h100, 32'h2); rd(0, 12'h100, "R6");
      wr(0, 12'h100, 32'h4); rd(0, 12'h100, "R6"); rd(0, 12'hFE0, "R6");
      // R5 channel clear
      wr(0, 12'h104, 32'hABCD_0000); wr(0, 12'h100, 32'h00FF_0001);
      wr(0, 12'h100, 32'h8000_0000);
      rd(0, 12'h100, "R5"); rd(0, 12'h104, "R5");
      // R9 enable mask gates starts, summary read-only
      wr(0, 12'hFF0, 32'hFFFF_FFFD); rd(0, 12'hFF0, "R9");
      wr(0, 12'h100, 32'h1); rd(0, 12'h100, "R7");
      wr(0, 12'hFF0, 32'h0000_FFFF);
      eng(3, 0, 0, 1); wr(0, 12'hFE0, 32'h0); rd(0, 12'hFE0, "R9");
      wr(0, 12'h300, 32'h4); rd(0, 12'hFE0, "R9");
      // R1 last-channel window
      wr(1, 12'h004, 32'h0F0F_0F00); rd(1, 12'h004, "R1"); rd(1, 12'hA04, "R1");
      rd(0, 12'hF04, "R1"); wr(0, 12'hE04, 32'h0E0E_0000); rd(0, 12'hE04, "R1");
      wr(1, 12'h000, 32'h1); rd(1, 12'h000, "R1");
      eng(NCH - 1, 1, 0, 0); rd(1, 12'h000, "R8");
      // R10 undefined offsets
      wr(0, 12'h024, 32'hFFFF_FFFF); rd(0, 12'h024, "R10");
      wr(0, 12'hF04, 32'h1); rd(0, 12'hF04, "R10"); rd(0, 12'hF00, "R10");
      wr(0, 12'h002, 32'hFFFF_FFFF); rd(0, 12'h000, "R10");
      idle(4);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule